// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one core and its private cache and tracks a single reservation for load-linked and store-conditional operations. A load-linked request records the cache line that holds the addressed word and marks the reservation valid. The reservation is lost in any of these cases:
- coherence traffic from another agent (a remote read or a remote write) touches that line;
- the line is evicted from the local cache;
- the core switches context.

A store-conditional commits its write only if the reservation is still valid and names the same line. The core gets back a result word that is one on success and zero on failure.

The core issues load-linked and store-conditional requests on a request port. The cache controller reports snoops and evictions on separate ports. The operating environment signals context switches on a single input. The cache data array is outside the block. A successful store-conditional appears on a write port toward the cache, together with its response, one cycle after the request.

Top module: `llsc_monitor`

## Requirements
- R1: With `req_valid_i` high, `req_op_i` = 2'b01 is a load-linked, 2'b10 is a store-conditional, and other codes do nothing. A load-linked sets a reservation on line `req_addr_i[ADDR_W-1:6]`. A later store-conditional to that line, with no event in between, succeeds: one cycle after it, `rsp_result_o` = 1 and `mem_we_o` = 1, with `mem_addr_o` and `mem_wdata_o` equal to the request address and data.
- R2: Lines are 64 bytes. Address bits [5:0] play no part in any line comparison, so offsets 0x00 and 0x3F fall in one line and 0x3F and 0x40 fall in two.
- R3: A snoop (`snp_valid_i`, for a remote read or a remote write) to the reserved line clears the reservation. A snoop to any other line has no effect.
- R4: An eviction notice (`evict_valid_i`) for the reserved line clears the reservation. An eviction of any other line has no effect.
- R5: A cycle with `ctx_switch_i` high clears the reservation.
- R6: A failing store-conditional returns `rsp_result_o` = 0 and leaves `mem_we_o` low.
- R7: Every store-conditional clears the reservation, whether it succeeds or fails.
- R8: A store-conditional to a line other than the reserved one fails.
- R9: A new load-linked replaces the existing reservation.
- R10: A snoop or eviction on the store-conditional's line, or a context switch, in the same cycle as the store-conditional makes it fail. The same events in the same cycle as a load-linked leave no reservation.
- R11: `rsp_valid_o` is high in exactly the cycle after each store-conditional. Reset (asynchronous, active low) clears the reservation and drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Core request valid |
| req_op_i | input | 2 | 01 load-linked, 10 store-conditional |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_wdata_i | input | DATA_W | Store-conditional data |
| snp_valid_i | input | 1 | Remote read or write snoop valid |
| snp_addr_i | input | ADDR_W | Snoop address |
| evict_valid_i | input | 1 | Local eviction notice valid |
| evict_addr_i | input | ADDR_W | Evicted line address |
| ctx_switch_i | input | 1 | Context switch pulse |
| rsp_valid_o | output | 1 | Store-conditional response valid |
| rsp_result_o | output | DATA_W | 1 on success, 0 on failure |
| mem_we_o | output | 1 | Commit write toward the cache |
| mem_addr_o | output | ADDR_W | Commit address |
| mem_wdata_o | output | DATA_W | Commit data |

## Verification
Every result of this block is due at the first rising edge after the store-conditional is presented: the response, the result code and the commit write all come from one register stage. A load-linked, snoop, eviction or context switch changes only internal state, which the next store-conditional exposes. The bench drives each stimulus on a falling edge and samples 5 ns after the following rising edge. For every store-conditional it checks both the response and the write port in that one window, and for every other operation it checks that no response appears.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_LL   = 2'b01,
    OP_SC   = 2'b10,
    OP_RSVD = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_line_match.sv
module llsc_line_match #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              ref_valid_i,
  input  logic [LINE_W-1:0] ref_line_i,
  input  logic              probe_valid_i,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic              hit_o
);
  logic [OFF_W-1:0] unused_off;
  assign unused_off = probe_addr_i[OFF_W-1:0];
  assign hit_o = ref_valid_i && probe_valid_i &&
                 (probe_addr_i[ADDR_W-1:OFF_W] == ref_line_i);
endmodule

// File: rtl/llsc_resv_track.sv
module llsc_resv_track #(
  parameter int LINE_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [LINE_W-1:0] set_line_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic [LINE_W-1:0] line_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      line_o  <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      line_o  <= set_line_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_sc_commit.sv
module llsc_sc_commit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sc_i,
  input  logic              ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_result_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic win;
  assign win = sc_i && ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_result_o <= '0;
      mem_we_o     <= 1'b0;
      mem_addr_o   <= '0;
      mem_wdata_o  <= '0;
    end else begin
      rsp_valid_o  <= sc_i;
      rsp_result_o <= DATA_W'(win);
      mem_we_o     <= win;
      // failed attempts leave the write port quiet
      mem_addr_o   <= win ? addr_i  : '0;
      mem_wdata_o  <= win ? wdata_i : '0;
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic              ctx_switch_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_result_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  // probe slots
  localparam int P_REQ_RESV = 0;
  localparam int P_SNP_RESV = 1;
  localparam int P_EV_RESV  = 2;
  localparam int P_SNP_REQ  = 3;
  localparam int P_EV_REQ   = 4;
  localparam int NPROBE     = 5;

  logic              is_ll, is_sc;
  logic              resv_valid;
  logic [LINE_W-1:0] resv_line, req_line;
  logic              set_ok, kill, sc_ok;

  logic [NPROBE-1:0] ref_vld, prb_vld, hit;
  logic [LINE_W-1:0] ref_line [NPROBE];
  logic [ADDR_W-1:0] prb_addr [NPROBE];

  assign is_ll    = req_valid_i && (llsc_op_e'(req_op_i) == OP_LL);
  assign is_sc    = req_valid_i && (llsc_op_e'(req_op_i) == OP_SC);
  assign req_line = req_addr_i[ADDR_W-1:OFF_W];

  always_comb begin
    ref_vld[P_REQ_RESV]  = resv_valid;  ref_line[P_REQ_RESV] = resv_line;
    prb_vld[P_REQ_RESV]  = is_sc;       prb_addr[P_REQ_RESV] = req_addr_i;
    ref_vld[P_SNP_RESV]  = resv_valid;  ref_line[P_SNP_RESV] = resv_line;
    prb_vld[P_SNP_RESV]  = snp_valid_i; prb_addr[P_SNP_RESV] = snp_addr_i;
    ref_vld[P_EV_RESV]   = resv_valid;  ref_line[P_EV_RESV]  = resv_line;
    prb_vld[P_EV_RESV]   = evict_valid_i; prb_addr[P_EV_RESV] = evict_addr_i;
    ref_vld[P_SNP_REQ]   = is_ll;       ref_line[P_SNP_REQ]  = req_line;
    prb_vld[P_SNP_REQ]   = snp_valid_i; prb_addr[P_SNP_REQ]  = snp_addr_i;
    ref_vld[P_EV_REQ]    = is_ll;       ref_line[P_EV_REQ]   = req_line;
    prb_vld[P_EV_REQ]    = evict_valid_i; prb_addr[P_EV_REQ] = evict_addr_i;
  end

  for (genvar p = 0; p < NPROBE; p++) begin : g_probe
    llsc_line_match #(
      .ADDR_W(ADDR_W),
      .OFF_W (OFF_W)
    ) i_match (
      .ref_valid_i  (ref_vld[p]),
      .ref_line_i   (ref_line[p]),
      .probe_valid_i(prb_vld[p]),
      .probe_addr_i (prb_addr[p]),
      .hit_o        (hit[p])
    );
  end

  // same-cycle kill events beat a store-conditional and block a load-linked
  assign sc_ok  = hit[P_REQ_RESV] && !hit[P_SNP_RESV] && !hit[P_EV_RESV] && !ctx_switch_i;
  assign set_ok = is_ll && !ctx_switch_i && !hit[P_SNP_REQ] && !hit[P_EV_REQ];
  assign kill   = is_sc || is_ll || ctx_switch_i || hit[P_SNP_RESV] || hit[P_EV_RESV];

  llsc_resv_track #(
    .LINE_W(LINE_W)
  ) i_resv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_ok),
    .set_line_i(req_line),
    .clr_i     (kill),
    .valid_o   (resv_valid),
    .line_o    (resv_line)
  );

  llsc_sc_commit #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_commit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sc_i        (is_sc),
    .ok_i        (sc_ok),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_result_o(rsp_result_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_op_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              snp_valid_i,
  input logic [ADDR_W-1:0] snp_addr_i,
  input logic              ctx_switch_i,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_result_o,
  input logic              mem_we_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic sc_req, snp_same;
  assign sc_req   = req_valid_i && (req_op_i == 2'b10);
  assign snp_same = snp_valid_i &&
                    (snp_addr_i[ADDR_W-1:OFF_W] == req_addr_i[ADDR_W-1:OFF_W]);

  AST_SC_RESPONDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_req |=> rsp_valid_o); // R11
  AST_NO_STRAY_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sc_req |=> !rsp_valid_o); // R11
  AST_FAIL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_result_o == '0) |-> !mem_we_o); // R6
  AST_WRITE_IS_SUCCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (rsp_valid_o && rsp_result_o == DATA_W'(1))); // R1
  AST_CTX_KILLS_SC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_req && ctx_switch_i) |=> (rsp_result_o == '0)); // R5
  AST_SNOOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_req && snp_same) |=> !mem_we_o); // R10
  AST_SC_CONSUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_req ##1 sc_req |=> (rsp_result_o == '0)); // R7
endmodule

bind llsc_monitor llsc_monitor_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .LINE_BYTES(LINE_BYTES)
) i_llsc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .req_addr_i  (req_addr_i),
  .snp_valid_i (snp_valid_i),
  .snp_addr_i  (snp_addr_i),
  .ctx_switch_i(ctx_switch_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_result_o(rsp_result_o),
  .mem_we_o    (mem_we_o)
);

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [1:0]    req_op_i = 2'b00;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          snp_valid_i = 1'b0;
  logic [AW-1:0] snp_addr_i = '0;
  logic          evict_valid_i = 1'b0;
  logic [AW-1:0] evict_addr_i = '0;
  logic          ctx_switch_i = 1'b0;
  logic          rsp_valid_o;
  logic [DW-1:0] rsp_result_o;
  logic          mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .DATA_W(DW), .LINE_BYTES(64)) i_llsc_monitor (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_op_i(req_op_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .snp_valid_i(snp_valid_i), .snp_addr_i(snp_addr_i),
    .evict_valid_i(evict_valid_i), .evict_addr_i(evict_addr_i),
    .ctx_switch_i(ctx_switch_i), .rsp_valid_o(rsp_valid_o),
    .rsp_result_o(rsp_result_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  localparam logic [1:0] NO = 2'b00, LL = 2'b01, SC = 2'b10;

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic          snp;
    logic          ev;
    logic          ctx;
    logic [AW-1:0] eaddr;
    logic          exp_rsp;
    logic          exp_ok;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{LL, 32'h1004, 0, 0, 0, 32'h0,    0, 0},
    '{SC, 32'h103C, 0, 0, 0, 32'h0,    1, 1},
    '{SC, 32'h1000, 0, 0, 0, 32'h0,    1, 0},
    '{LL, 32'h1000, 0, 0, 0, 32'h0,    0, 0},
    '{NO, 32'h0,    1, 0, 0, 32'h2000, 0, 0},
    '{NO, 32'h0,    0, 1, 0, 32'h2010, 0, 0},
    '{SC, 32'h1008, 0, 0, 0, 32'h0,    1, 1},
    '{LL, 32'h1000, 0, 0, 0, 32'h0,    0, 0},
    '{NO, 32'h0,    1, 0, 0, 32'h1020, 0, 0},
    '{SC, 32'h1000, 0, 0, 0, 32'h0,    1, 0},
    '{LL, 32'h1000, 0, 0, 0, 32'h0,    0, 0},
    '{NO, 32'h0,    0, 1, 0, 32'h1004, 0, 0},
    '{SC, 32'h1000, 0, 0, 0, 32'h0,    1, 0},
    '{LL, 32'h1000, 0, 0, 0, 32'h0,    0, 0},
    '{NO, 32'h0,    0, 0, 1, 32'h0,    0, 0},
    '{SC, 32'h1000, 0, 0, 0, 32'h0,    1, 0},
    '{LL, 32'h1000, 0, 0, 0, 32'h0,    0, 0},
    '{SC, 32'h2000, 0, 0, 0, 32'h0,    1, 0},
    '{SC, 32'h1000, 0, 0, 0, 32'h0,    1, 0},
    '{LL, 32'h1000, 0, 0, 0, 32'h0,    0, 0},
    '{LL, 32'h2000, 0, 0, 0, 32'h0,    0, 0},
    '{SC, 32'h1000, 0, 0, 0, 32'h0,    1, 0},
    '{LL, 32'h1000, 0, 0, 0, 32'h0,    0, 0},
    '{LL, 32'h2000, 0, 0, 0, 32'h0,    0, 0},
    '{SC, 32'h2004, 0, 0, 0, 32'h0,    1, 1},
    '{LL, 32'h1000, 0, 0, 0, 32'h0,    0, 0},
    '{SC, 32'h1000, 1, 0, 0, 32'h1010, 1, 0},
    '{LL, 32'h1000, 1, 0, 0, 32'h1000, 0, 0},
    '{SC, 32'h1000, 0, 0, 0, 32'h0,    1, 0},
    '{LL, 32'h1040, 0, 0, 0, 32'h0,    0, 0},
    '{SC, 32'h107F, 0, 0, 0, 32'h0,    1, 1},
    '{LL, 32'h103F, 0, 0, 0, 32'h0,    0, 0},
    '{SC, 32'h1040, 0, 0, 0, 32'h0,    1, 0}
  };

  localparam string TAGS [NV] = '{
    "R1", "R2", "R7", "R3", "R3", "R4", "R3", "R3", "R3", "R3", "R4",
    "R4", "R4", "R5", "R5", "R5", "R8", "R8", "R7", "R9", "R9", "R9",
    "R9", "R9", "R9", "R10", "R10", "R10", "R10", "R2", "R2", "R8", "R8"
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample 5 ns after the next rising edge
  task automatic apply(input logic [1:0] op, input logic [AW-1:0] addr,
                       input logic [DW-1:0] wd, input logic snp, input logic ev,
                       input logic ctx, input logic [AW-1:0] eaddr);
    @(negedge clk);
    req_valid_i   = (op != NO);
    req_op_i      = op;
    req_addr_i    = addr;
    req_wdata_i   = wd;
    snp_valid_i   = snp;
    snp_addr_i    = eaddr;
    evict_valid_i = ev;
    evict_addr_i  = eaddr;
    ctx_switch_i  = ctx;
    @(posedge clk);
    #5;
  endtask

  task automatic idle();
    apply(NO, '0, '0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic expect_sc(input string tag, input logic ok,
                           input logic [AW-1:0] addr, input logic [DW-1:0] wd);
    check(tag, {63'd0, rsp_valid_o}, 64'd1);
    check(tag, {32'd0, rsp_result_o}, ok ? 64'd1 : 64'd0);
    check(ok ? tag : "R6", {63'd0, mem_we_o}, {63'd0, ok});
    if (ok) begin
      check(tag, {32'd0, mem_addr_o}, {32'd0, addr});
      check(tag, {32'd0, mem_wdata_o}, {32'd0, wd});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // reset state, R11
    repeat (3) @(posedge clk);
    #5;
    check("R11", {63'd0, rsp_valid_o}, 64'd0);
    check("R11", {63'd0, mem_we_o}, 64'd0);
    check("R11", {32'd0, rsp_result_o}, 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    // no reservation after reset, R6
    apply(SC, 32'h1000, 32'hAAAA_0001, 0, 0, 0, '0);
    expect_sc("R6", 1'b0, '0, '0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [DW-1:0] wd;
      wd = 32'hC0DE_0000 | DW'(i);
      apply(VECS[i].op, VECS[i].addr, wd, VECS[i].snp, VECS[i].ev, VECS[i].ctx,
            VECS[i].eaddr);
      if (VECS[i].exp_rsp)
        expect_sc(TAGS[i], VECS[i].exp_ok, VECS[i].addr, wd);
      else
        check(TAGS[i], {63'd0, rsp_valid_o}, 64'd0);
    end

    // idle cycle gives no response, R11
    idle();
    check("R11", {63'd0, rsp_valid_o}, 64'd0);

    // context switch in the same cycle as a store-conditional, R10
    apply(LL, 32'h3000, '0, 0, 0, 0, '0);
    apply(SC, 32'h3000, 32'h1234_5678, 0, 0, 1, '0);
    expect_sc("R10", 1'b0, '0, '0);

    // eviction in the same cycle as a load-linked, R10
    apply(LL, 32'h3000, '0, 0, 1, 0, 32'h3008);
    apply(SC, 32'h3000, 32'h1111_2222, 0, 0, 0, '0);
    expect_sc("R10", 1'b0, '0, '0);

    // eviction of the reserved line in the same cycle as the store-conditional, R10
    apply(LL, 32'h3000, '0, 0, 0, 0, '0);
    apply(SC, 32'h3010, 32'h3333_4444, 0, 1, 0, 32'h3000);
    expect_sc("R10", 1'b0, '0, '0);

    // reserved-line LL then clean SC still works after all of the above, R1
    apply(LL, 32'h4000, '0, 0, 0, 0, '0);
    apply(SC, 32'h4020, 32'h5555_6666, 0, 0, 0, '0);
    expect_sc("R1", 1'b1, 32'h4020, 32'h5555_6666);

    // asynchronous reset drops a live reservation, R11
    apply(LL, 32'h5000, '0, 0, 0, 0, '0);
    idle();
    @(negedge clk);
    rst_ni = 1'b0;
    #3;
    check("R11", {63'd0, rsp_valid_o}, 64'd0);
    #2;
    rst_ni = 1'b1;
    apply(SC, 32'h5000, 32'h7777_8888, 0, 0, 0, '0);
    expect_sc("R11", 1'b0, '0, '0);
    idle();

    finish_run();
  end
endmodule